// File: doc/BRIEF.md
# Burst Serial Master with Programmable Framing

This block is a full-duplex synchronous serial master for one slave device. Software reaches it through a small register port with APB-style setup and access phases. It fills up to four 32-bit data slots and picks a word length of 1 to 32 bits, a word count of 1 to 4, the bit order, the edge that launches data and the edge that captures it. It also sets the select polarity and a clock divisor. Setting the start bit then runs the whole burst without help from software.

Each slot supplies one outgoing word and is overwritten with the word captured during that slot's frame. The select line stays active from the first launched bit until half a serial period after the last falling clock edge of the burst. The block then clears its start bit and sets a completion flag. That flag can drive an interrupt line, and software clears it by writing one.

Top module: `spi_burst_master`

## Requirements
- R1: Four 32-bit slots sit at addresses 0x10, 0x14, 0x18 and 0x1C. Slot i supplies word i of the burst and afterwards holds the word received in that frame, with bits at and above the word length read as zero.
- R2: The word length is the CTRL field at bits [12:8] plus one (1 to 32). For a word shorter than 32 bits, only bits [length-1:0] of the slot are sent.
- R3: The number of words is the CTRL field at bits [7:6] plus one. Words follow each other with no idle serial clock between them, and slots beyond the count keep their contents.
- R4: CTRL bit 1 picks the order for both directions. With 0, bit length-1 goes first. With 1, bit 0 goes first.
- R5: CTRL bit 2 set makes outgoing data change on rising serial clock edges, and clear makes it change on falling edges. CTRL bit 3 set samples incoming data on rising edges, and clear samples on falling edges. The first bit of each word is on the data line before that word's first rising edge.
- R6: CTRL bit 4 set makes the select output active-high, and clear makes it active-low. It rests at the inactive level outside a transfer.
- R7: Each serial clock half period lasts DIV+1 system clocks, where DIV is bits [15:0] at address 0x08. The serial clock rests low outside a transfer.
- R8: Writing 1 to CTRL bit 0 starts a burst, and the bit reads 1 until the burst ends. At the end the hardware clears it and sets STAT bit 0 (address 0x04). Writing 1 to STAT bit 0 clears the flag, and writing 0 leaves it set.
- R9: After reset, CTRL, STAT and DIV read zero, the serial clock and data outputs are low, the select output is high and the interrupt is low.
- R10: While CTRL bit 0 is set, writes to the slots, to DIV and to CTRL are dropped.
- R11: The select stays active across the whole burst and goes inactive DIV+1 system clocks after the final falling serial clock edge.
- R12: The interrupt output goes high one clock after STAT bit 0 and CTRL bit 5 are both set, and low one clock after either clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| sclk | output | 1 | Serial clock |
| ss | output | 1 | Slave select, polarity from CTRL bit 4 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check, on every cycle, that the serial clock rests low while idle and only toggles while select is active. They also check that the bit and word counters never pass the programmed length and count, that the tail phase keeps select active with the clock low, that completion clears the start bit and sets the flag together, and that a divisor write during a burst leaves the divisor unchanged. Only the bench's scenarios can show the bit order and edge choice on the wire, the half-period and tail lengths, the data captured into each slot and the slots left untouched, the dropped slot writes, and the interrupt's timing. The bench shows these by looping the inverted data line back as input and recording the line at each capture edge.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {S_IDLE, S_BIT, S_TAIL} eng_state_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DIV  = 2'd2;

  localparam int CB_GO    = 0;
  localparam int CB_LSB   = 1;
  localparam int CB_TXR   = 2;
  localparam int CB_RXR   = 3;
  localparam int CB_SSH   = 4;
  localparam int CB_IE    = 5;
  localparam int CB_BURST = 6;
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else               cnt <= cnt + DIV_W'(1);
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBUF   = 4,
  parameter int DIV_W  = 16,
  localparam int IDX_W = $clog2(NBUF),
  localparam int LEN_W = $clog2(DATA_W),
  localparam int AW    = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              go,
  output logic              lsb,
  output logic              tx_rise,
  output logic              rx_rise,
  output logic              ss_hi,
  output logic [LEN_W-1:0]  len_m1,
  output logic [IDX_W-1:0]  burst_m1,
  output logic [DIV_W-1:0]  div,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  output logic              irq
);
  localparam int LEN_LSB = CB_BURST + IDX_W;

  logic              ie, flag;
  logic [DATA_W-1:0] mem [NBUF];
  logic [DATA_W-1:0] ctrl_rd;
  logic              wr, is_data;
  logic [1:0]        rsel;
  logic [IDX_W-1:0]  widx;

  assign wr      = psel && penable && pwrite;
  assign is_data = paddr[AW-1];
  assign rsel    = paddr[3:2];
  assign widx    = paddr[2 +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      go <= 1'b0; lsb <= 1'b0; tx_rise <= 1'b0; rx_rise <= 1'b0;
      ss_hi <= 1'b0; ie <= 1'b0; len_m1 <= '0; burst_m1 <= '0;
      div <= '0; flag <= 1'b0; irq <= 1'b0;
    end else begin
      if (eng_done) go <= 1'b0;
      else if (wr && !is_data && rsel == RA_CTRL && !go) begin
        go       <= pwdata[CB_GO];
        lsb      <= pwdata[CB_LSB];
        tx_rise  <= pwdata[CB_TXR];
        rx_rise  <= pwdata[CB_RXR];
        ss_hi    <= pwdata[CB_SSH];
        ie       <= pwdata[CB_IE];
        burst_m1 <= pwdata[CB_BURST +: IDX_W];
        len_m1   <= pwdata[LEN_LSB +: LEN_W];
      end
      if (wr && !is_data && rsel == RA_DIV && !go) div <= pwdata[DIV_W-1:0];
      if (eng_done) flag <= 1'b1;
      else if (wr && !is_data && rsel == RA_STAT && pwdata[0]) flag <= 1'b0;
      irq <= flag && ie;
    end
  end

  // Slot storage: no reset, one write port selected by priority
  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_idx] <= eng_wdata;
    else if (wr && is_data && !go) mem[widx] <= pwdata;
  end

  assign rd_data = mem[rd_idx];

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_GO]  = go;
    ctrl_rd[CB_LSB] = lsb;
    ctrl_rd[CB_TXR] = tx_rise;
    ctrl_rd[CB_RXR] = rx_rise;
    ctrl_rd[CB_SSH] = ss_hi;
    ctrl_rd[CB_IE]  = ie;
    ctrl_rd[CB_BURST +: IDX_W] = burst_m1;
    ctrl_rd[LEN_LSB +: LEN_W]  = len_m1;
  end

  always_ff @(posedge clk) begin
    if (rst) prdata <= '0;
    else if (psel && !penable && !pwrite) begin
      if (is_data) prdata <= mem[widx];
      else begin
        case (rsel)
          RA_CTRL: prdata <= ctrl_rd;
          RA_STAT: prdata <= DATA_W'(flag);
          RA_DIV:  prdata <= DATA_W'(div);
          default: prdata <= '0;
        endcase
      end
    end
  end

  p_done_flag_r8: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> (flag && !go));
  p_busy_div_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !is_data && rsel == RA_DIV && go) |=> $stable(div));
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBUF   = 4,
  localparam int IDX_W = $clog2(NBUF),
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              tick,
  input  logic              lsb,
  input  logic              tx_rise,
  input  logic              rx_rise,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [IDX_W-1:0]  burst_m1,
  input  logic              miso,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              run,
  output logic              sclk,
  output logic              ss_act,
  output logic              mosi,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  eng_state_t        state;
  logic [LEN_W-1:0]  bcnt;
  logic [IDX_W-1:0]  wcnt;
  logic [DATA_W-1:0] txw, rxw, rx_next;
  logic              rise_evt, fall_evt, samp, last_bit, last_word;

  function automatic logic [LEN_W-1:0] pos(input logic [LEN_W-1:0] k);
    return lsb ? k : len_m1 - k;
  endfunction

  assign rise_evt  = (state == S_BIT) && tick && !sclk;
  assign fall_evt  = (state == S_BIT) && tick && sclk;
  assign last_bit  = (bcnt == len_m1);
  assign last_word = (wcnt == burst_m1);
  assign samp      = rx_rise ? rise_evt : fall_evt;
  assign run       = (state != S_IDLE);
  assign rd_idx    = (state == S_IDLE) ? '0 : wcnt + IDX_W'(1);
  assign wr_en     = fall_evt && last_bit;
  assign wr_idx    = wcnt;
  assign wr_data   = rx_next;
  assign done      = (state == S_TAIL) && tick;

  always_comb begin
    rx_next = rxw;
    if (samp) rx_next[pos(bcnt)] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; bcnt <= '0; wcnt <= '0; txw <= '0; rxw <= '0;
      sclk <= 1'b0; ss_act <= 1'b0; mosi <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state  <= S_BIT;
          bcnt   <= '0;
          wcnt   <= '0;
          txw    <= rd_data;
          rxw    <= '0;
          ss_act <= 1'b1;
          mosi   <= rd_data[pos('0)];
        end
        S_BIT: begin
          rxw <= rx_next;
          if (rise_evt) begin
            sclk <= 1'b1;
            if (tx_rise && bcnt != '0) mosi <= txw[pos(bcnt)];
          end
          if (fall_evt) begin
            sclk <= 1'b0;
            if (last_bit) begin
              bcnt <= '0;
              if (last_word) state <= S_TAIL;
              else begin
                wcnt <= wcnt + IDX_W'(1);
                txw  <= rd_data;
                rxw  <= '0;
                mosi <= rd_data[pos('0)];
              end
            end else begin
              bcnt <= bcnt + LEN_W'(1);
              if (!tx_rise) mosi <= txw[pos(bcnt + LEN_W'(1))];
            end
          end
        end
        S_TAIL: if (tick) begin
          state  <= S_IDLE;
          ss_act <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sclk);
  p_bitcnt_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_BIT) |-> (bcnt <= len_m1));
  p_wordcnt_r3: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> (wcnt <= burst_m1));
  p_tail_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_TAIL) |-> (ss_act && !sclk));
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DATA_W = 32,
  parameter int NBUF   = 4,
  parameter int DIV_W  = 16,
  localparam int IDX_W = $clog2(NBUF),
  localparam int LEN_W = $clog2(DATA_W),
  localparam int AW    = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              sclk,
  output logic              ss,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic              go, lsb, tx_rise, rx_rise, ss_hi, tick, run, ss_act;
  logic              eng_we, eng_done;
  logic [LEN_W-1:0]  len_m1;
  logic [IDX_W-1:0]  burst_m1, rd_idx, eng_idx;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] rd_data, eng_wdata;

  spi_regs #(.DATA_W(DATA_W), .NBUF(NBUF), .DIV_W(DIV_W)) u_regs (
    .clk, .rst, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .go, .lsb, .tx_rise, .rx_rise, .ss_hi, .len_m1, .burst_m1, .div,
    .rd_idx, .rd_data, .eng_we, .eng_idx, .eng_wdata, .eng_done, .irq
  );

  spi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk, .rst, .run, .div, .tick
  );

  spi_shift #(.DATA_W(DATA_W), .NBUF(NBUF)) u_shift (
    .clk, .rst, .go, .tick, .lsb, .tx_rise, .rx_rise, .len_m1, .burst_m1,
    .miso, .rd_data, .rd_idx, .run, .sclk, .ss_act, .mosi,
    .wr_en(eng_we), .wr_idx(eng_idx), .wr_data(eng_wdata), .done(eng_done)
  );

  assign ss = ss_act ? ss_hi : !ss_hi;

  p_ss_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (sclk != $past(sclk)) |-> ss_act);
endmodule

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        sclk, ss, mosi, miso, irq;

  always #2 clk = ~clk;
  assign miso = ~mosi;

  spi_burst_master dut (
    .clk, .rst, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .sclk, .ss, .mosi, .miso, .irq
  );

  int nchk = 0, nfail = 0;

  // len_m1[15:11] burst_m1[10:9] lsb[8] txr[7] rxr[6] unused[5:4] div[3:0]
  localparam logic [15:0] VEC [6] = '{
    {5'd7,  2'd0, 1'b0, 1'b0, 1'b1, 2'b0, 4'd0},
    {5'd31, 2'd3, 1'b1, 1'b1, 1'b0, 2'b0, 4'd1},
    {5'd0,  2'd1, 1'b0, 1'b0, 1'b1, 2'b0, 4'd2},
    {5'd12, 2'd2, 1'b1, 1'b0, 1'b1, 2'b0, 4'd3},
    {5'd31, 2'd0, 1'b0, 1'b1, 1'b0, 2'b0, 4'd0},
    {5'd4,  2'd3, 1'b0, 1'b1, 1'b0, 2'b0, 4'd1}
  };

  // Line monitor
  logic mon_en = 1'b0, mon_act = 1'b0, mon_rxr = 1'b1;
  logic p_sclk = 1'b0, p_mosi = 1'b0, p_ss = 1'b1;
  logic cap [256];
  int   ncap = 0, gap = 0, gap_bad = 0, ss_bad = 0, tail = -1, exp_half = 1;
  bit   have_tr = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      gap++;
      if (sclk != p_sclk) begin
        if (ss != mon_act) ss_bad++;
        if (have_tr && gap != exp_half) gap_bad++;
        if ((sclk && mon_rxr) || (!sclk && !mon_rxr)) begin
          if (ncap < 256) cap[ncap] = p_mosi;
          ncap++;
        end
        have_tr = 1;
        gap = 0;
      end
      if (ss != p_ss && ss != mon_act) tail = gap;
    end
    p_sclk = sclk; p_mosi = mosi; p_ss = ss;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] r;
    ok = 0;
    for (int n = 0; n < 4000; n++) begin
      apb_rd(5'h04, r);
      if (r[0]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] gen(input int v, input int i);
    return (32'h9E3779B9 * 32'(v * 4 + i + 1)) ^ 32'h5A0F3C96;
  endfunction

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] mk_ctrl(input int lm1, input int bm1, input bit lsbf,
      input bit txr, input bit rxr, input bit ssh, input bit ie, input bit g);
    return (32'(lm1) << 8) | (32'(bm1) << 6) | (32'(ie) << 5) | (32'(ssh) << 4)
         | (32'(rxr) << 3) | (32'(txr) << 2) | (32'(lsbf) << 1) | 32'(g);
  endfunction

  task automatic arm(input bit act, input bit rxr, input int d);
    mon_act = act; mon_rxr = rxr; exp_half = d + 1;
    ncap = 0; gap = 0; gap_bad = 0; ss_bad = 0; tail = -1; have_tr = 0;
    mon_en = 1;
  endtask

  task automatic run_vec(input int v);
    logic [15:0] f;
    logic [31:0] tw [4];
    logic [31:0] r;
    int len, nw, d, bad;
    bit lsbf, txr, rxr, ok;
    f = VEC[v];
    len = int'(f[15:11]) + 1; nw = int'(f[10:9]) + 1;
    lsbf = f[8]; txr = f[7]; rxr = f[6]; d = int'(f[3:0]);
    apb_wr(5'h08, 32'(d));
    for (int i = 0; i < 4; i++) begin
      tw[i] = gen(v, i);
      apb_wr(5'(16 + 4 * i), tw[i]);
    end
    arm(1'b0, rxr, d);
    apb_wr(5'h00, mk_ctrl(len - 1, nw - 1, lsbf, txr, rxr, 0, 0, 1));
    wait_done(ok);
    mon_en = 0;
    chk(ok, "R8", "completion flag", ok, 1);
    // R4 R5: bits seen on the line at capture edges, in order
    chk(ncap == len * nw, "R2", "bit count on line", ncap, len * nw);
    bad = 0;
    for (int w = 0; w < nw; w++)
      for (int k = 0; k < len; k++) begin
        int p, j;
        p = lsbf ? k : len - 1 - k;
        j = w * len + k;
        if (j < 256 && cap[j] != tw[w][p]) bad++;
      end
    chk(bad == 0, "R4", "line bit order/edges (R5)", bad, 0);
    chk(gap_bad == 0, "R7", "half period", gap_bad, 0);
    chk(tail == d + 1, "R11", "select tail", tail, d + 1);
    chk(ss_bad == 0, "R11", "select held", ss_bad, 0);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] e;
      apb_rd(5'(16 + 4 * i), r);
      e = (i < nw) ? (~tw[i] & lmask(len)) : tw[i];
      chk(r == e, (i < nw) ? "R1" : "R3", "slot contents", r, e);
    end
    apb_rd(5'h00, r);
    chk(r[0] == 0, "R8", "go cleared", r[0], 0);
    chk(irq == 0, "R12", "irq masked", irq, 0);
    apb_wr(5'h04, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    repeat (5) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(sclk == 0, "R9", "sclk reset", sclk, 0);
    chk(ss == 1, "R9", "ss reset", ss, 1);
    chk(mosi == 0, "R9", "mosi reset", mosi, 0);
    chk(irq == 0, "R9", "irq reset", irq, 0);
    apb_rd(5'h00, r); chk(r == 0, "R9", "CTRL reset", r, 0);
    apb_rd(5'h04, r); chk(r == 0, "R9", "STAT reset", r, 0);
    apb_rd(5'h08, r); chk(r == 0, "R9", "DIV reset", r, 0);

    for (int v = 0; v < 6; v++) run_vec(v);

    // R10: writes dropped while busy; R8 go reads 1 while running
    apb_wr(5'h08, 32'd3);
    apb_wr(5'h10, 32'h1234_ABCD);
    apb_wr(5'h14, 32'h0BAD_F00D);
    arm(1'b0, 1'b1, 3);
    apb_wr(5'h00, mk_ctrl(15, 0, 0, 0, 1, 0, 0, 1));
    apb_wr(5'h14, 32'hDEAD_BEEF);
    apb_wr(5'h08, 32'd9);
    apb_wr(5'h00, mk_ctrl(3, 2, 1, 1, 0, 0, 0, 1));
    apb_rd(5'h00, r);
    chk(r[0] == 1, "R8", "go while busy", r[0], 1);
    wait_done(ok);
    mon_en = 0;
    chk(ok, "R8", "directed completion", ok, 1);
    apb_rd(5'h14, r); chk(r == 32'h0BAD_F00D, "R10", "slot write dropped", r, 32'h0BAD_F00D);
    apb_rd(5'h08, r); chk(r == 3, "R10", "DIV write dropped", r, 3);
    apb_rd(5'h00, r); chk(r[12:8] == 15, "R10", "CTRL write dropped", r[12:8], 15);
    apb_rd(5'h10, r); chk(r == (~32'h1234_ABCD & 32'hFFFF), "R1", "16-bit receive", r, ~32'h1234_ABCD & 32'hFFFF);
    chk(tail == 4, "R11", "tail div3", tail, 4);
    // R8: writing 0 keeps flag, writing 1 clears it
    apb_wr(5'h04, 32'h0);
    apb_rd(5'h04, r); chk(r[0] == 1, "R8", "W0 keeps flag", r[0], 1);
    apb_wr(5'h04, 32'h1);
    apb_rd(5'h04, r); chk(r[0] == 0, "R8", "W1C clears flag", r[0], 0);

    // R6 active-high select, R12 interrupt
    apb_wr(5'h08, 32'd0);
    apb_wr(5'h00, mk_ctrl(9, 1, 0, 0, 1, 1, 1, 0));
    @(negedge clk);
    chk(ss == 0, "R6", "active-high idle level", ss, 0);
    arm(1'b1, 1'b1, 0);
    apb_wr(5'h00, mk_ctrl(9, 1, 0, 0, 1, 1, 1, 1));
    wait_done(ok);
    mon_en = 0;
    chk(ss_bad == 0, "R6", "select high during burst", ss_bad, 0);
    chk(ss == 0, "R6", "select back to idle", ss, 0);
    chk(irq == 1, "R12", "irq raised", irq, 1);
    apb_wr(5'h04, 32'h1);
    @(negedge clk);
    chk(irq == 0, "R12", "irq cleared", irq, 0);
    chk(sclk == 0, "R7", "sclk idle low", sclk, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule